// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block gathers interrupt requests from a numbered set of sources (IDs 1 to `N_SRC`, with ID 0 reserved) and presents them to a small number of processor contexts. Each source passes through a gateway that latches the request as pending. A per-source parameter bit selects level-high or rising-edge capture. Software gives every source a 3-bit priority. For each context it sets an enable bit per source and a 3-bit threshold. A context's interrupt line is high while at least one source is pending, enabled for that context, and has a priority strictly above that context's threshold.

Software services a context by reading its claim register. The read returns the winning source ID and clears that source's pending state. The gateway then holds the source back until software writes the same ID to the claim register as a completion. All registers are 32-bit words on a simple register bus with separate read and write strobes. Read data is registered and valid in the cycle after the read strobe.

Top module: `plic_core`

## Requirements
- R1: After reset every priority, enable bit and threshold reads 0, every `ctx_irq` line is low and a claim read returns 0.
- R2: The priority of source ID i is the word at byte offset 4*i and keeps the low 3 bits of the written value. The word for ID 0 reads 0 and ignores writes.
- R3: Context c's enable word w is at byte offset 0x2000 + 0x80*c + 4*w. Source ID i is bit (i mod 32) of word (i / 32). Bit 0 of word 0 (ID 0) always reads 0, and each context's enables are independent.
- R4: Context c's threshold is at byte offset 0x200000 + 0x1000*c and keeps 3 bits. Its claim/complete register is at that offset + 4. Read data appears in the cycle after the read strobe.
- R5: `ctx_irq[c]` is high exactly when some source is pending, enabled for context c, and has priority strictly greater than context c's threshold. A threshold of 7 silences the context, and priority 0 never interrupts.
- R6: A claim read returns the eligible source with the highest priority, and the lowest ID among equal priorities. It clears that source's pending state. When nothing is eligible it returns 0.
- R7: A claimed source cannot become pending again until its ID is completed, even while its level input stays high. After completion, a level input that is still high pends again.
- R8: An edge-mode source pends once per rising edge. An input held high after its edge does not pend again after completion.
- R9: Rising edges that arrive while an edge-mode source is claimed are kept as at most one pending request. It becomes pending at completion.
- R10: A completion write of ID 0, or of an ID not enabled for the writing context, has no effect.
- R11: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Source requests; bit k is source ID k+1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (claim side effect) |
| reg_addr | input | 22 | Byte address; bits 1:0 ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| ctx_irq | output | N_CTX | Interrupt line per context |

## Verification
The assertions check these properties on every cycle:
- A gateway is never pending and claimed at the same time.
- A claim strobe targets at most one source, and that source was pending.
- A claimed source leaves the pending state and holds the claim.
- A threshold of 7 keeps its context's line low.
- A claim read with the line low returns 0.

Other behaviours depend on a sequence of events, so only the bench scenarios can show them:
- tie-breaking on the lowest ID;
- re-pending of a level source after completion;
- the single remembered edge;
- completions that are ignored for the wrong context or for ID 0;
- the address decode of every register window.

// File: rtl/plic_pkg.sv
package plic_pkg;

    localparam int unsigned PRIO_W      = 3;
    localparam int unsigned ADDR_W      = 22;
    localparam int unsigned ENAB_BASE   = 32'h0000_2000;
    localparam int unsigned ENAB_STRIDE = 32'h0000_0080;
    localparam int unsigned CTRL_BASE   = 32'h0020_0000;
    localparam int unsigned CTRL_STRIDE = 32'h0000_1000;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_ENAB,
        RG_THR,
        RG_CLAIM
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] ctx;
        logic [9:0] idx;
    } reg_sel_t;

    // Map a byte address onto a register class, context and index.
    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] addr,
                                        input int unsigned nsrc,
                                        input int unsigned nctx,
                                        input int unsigned nwords);
        reg_sel_t    sel;
        int unsigned a;
        int unsigned off;
        sel = '{kind: RG_NONE, ctx: '0, idx: '0};
        a   = {10'b0, addr[ADDR_W-1:2], 2'b00};
        if (a < 4 * (nsrc + 1)) begin
            sel.kind = RG_PRIO;
            sel.idx  = 10'(a >> 2);
        end else if (a >= ENAB_BASE && a < ENAB_BASE + nctx * ENAB_STRIDE) begin
            off = a - ENAB_BASE;
            if (((off % ENAB_STRIDE) >> 2) < nwords) begin
                sel.kind = RG_ENAB;
                sel.ctx  = 8'(off / ENAB_STRIDE);
                sel.idx  = 10'((off % ENAB_STRIDE) >> 2);
            end
        end else if (a >= CTRL_BASE && a < CTRL_BASE + nctx * CTRL_STRIDE) begin
            off     = a - CTRL_BASE;
            sel.ctx = 8'(off / CTRL_STRIDE);
            if ((off % CTRL_STRIDE) == 0) begin
                sel.kind = RG_THR;
            end else if ((off % CTRL_STRIDE) == 4) begin
                sel.kind = RG_CLAIM;
            end
        end
        return sel;
    endfunction

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pend_o,
    output logic busy_o
);

    logic prev_q;
    logic memo_q;
    logic pend_q;
    logic busy_q;
    logic rise;
    logic fire;

    always_comb begin
        rise = req_i & ~prev_q;
        fire = EDGE ? rise : req_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            memo_q <= 1'b0;
            pend_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            prev_q <= req_i;
            if (claim_i) begin
                pend_q <= 1'b0;
                busy_q <= 1'b1;
                memo_q <= EDGE & rise;
            end else if (complete_i && busy_q) begin
                busy_q <= 1'b0;
                memo_q <= 1'b0;
                if (memo_q || (EDGE && rise)) begin
                    pend_q <= 1'b1;
                end
            end else if (fire) begin
                if (!busy_q) begin
                    pend_q <= 1'b1;
                end else if (EDGE) begin
                    memo_q <= 1'b1;
                end
            end
        end
    end

    assign pend_o = pend_q;
    assign busy_o = busy_q;

endmodule

// File: rtl/plic_ctx_arb.sv
module plic_ctx_arb
    import plic_pkg::*;
#(
    parameter int unsigned N_SRC = 31,
    localparam int unsigned ID_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0]             pend_i,
    input  logic [N_SRC-1:0]             en_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]            thr_i,
    output logic [ID_W-1:0]              best_o,
    output logic                         irq_o
);

    logic [PRIO_W-1:0] best_p;

    // Strict comparison keeps the lowest ID among equal priorities.
    always_comb begin
        best_o = '0;
        best_p = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (pend_i[k] && en_i[k] && prio_i[k] > thr_i && prio_i[k] > best_p) begin
                best_p = prio_i[k];
                best_o = ID_W'(k + 1);
            end
        end
        irq_o = (best_o != '0);
    end

endmodule

// File: rtl/plic_core.sv
module plic_core
    import plic_pkg::*;
#(
    parameter int unsigned       N_SRC     = 31,
    parameter int unsigned       N_CTX     = 2,
    parameter logic [N_SRC-1:0]  EDGE_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_req,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [21:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [N_CTX-1:0]  ctx_irq
);

    localparam int unsigned ID_W    = $clog2(N_SRC + 1);
    localparam int unsigned N_WORDS = (N_SRC + 1 + 31) / 32;

    logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [N_CTX-1:0][N_SRC-1:0]  enab_q;
    logic [N_CTX-1:0][PRIO_W-1:0] thr_q;
    logic [31:0]                  rdata_q;

    logic [N_SRC-1:0]             gw_pend;
    logic [N_SRC-1:0]             gw_busy;
    logic [N_SRC-1:0]             claim_vec;
    logic [N_SRC-1:0]             cmpl_vec;
    logic [N_CTX-1:0][ID_W-1:0]   best_id;
    logic [ID_W-1:0]              sel_best;
    logic [31:0]                  rd_mux;
    reg_sel_t                     sel;

    assign sel = decode(reg_addr, N_SRC, N_CTX, N_WORDS);

    // Gateways, one per source; the mask picks the capture mode.
    for (genvar k = 0; k < N_SRC; k++) begin : g_gw
        plic_gateway #(.EDGE(EDGE_MASK[k])) u_gw (
            .clk        (clk),
            .rst        (rst),
            .req_i      (src_req[k]),
            .claim_i    (claim_vec[k]),
            .complete_i (cmpl_vec[k]),
            .pend_o     (gw_pend[k]),
            .busy_o     (gw_busy[k])
        );
    end

    // Per-context winner selection.
    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        plic_ctx_arb #(.N_SRC(N_SRC)) u_arb (
            .pend_i (gw_pend),
            .en_i   (enab_q[c]),
            .prio_i (prio_q),
            .thr_i  (thr_q[c]),
            .best_o (best_id[c]),
            .irq_o  (ctx_irq[c])
        );
    end

    // Claim and completion strobes toward the gateways.
    always_comb begin
        sel_best  = '0;
        claim_vec = '0;
        cmpl_vec  = '0;
        for (int c = 0; c < N_CTX; c++) begin
            if (sel.ctx == 8'(c)) begin
                sel_best = best_id[c];
            end
        end
        for (int k = 0; k < N_SRC; k++) begin
            if (reg_rd && sel.kind == RG_CLAIM && sel_best == ID_W'(k + 1)) begin
                claim_vec[k] = 1'b1;
            end
            for (int c = 0; c < N_CTX; c++) begin
                if (reg_wr && sel.kind == RG_CLAIM && sel.ctx == 8'(c)
                    && reg_wdata == 32'(k + 1) && enab_q[c][k]) begin
                    cmpl_vec[k] = 1'b1;
                end
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_mux = '0;
        unique case (sel.kind)
            RG_PRIO: begin
                for (int k = 0; k < N_SRC; k++) begin
                    if (sel.idx == 10'(k + 1)) rd_mux = 32'(prio_q[k]);
                end
            end
            RG_ENAB: begin
                for (int c = 0; c < N_CTX; c++) begin
                    for (int k = 0; k < N_SRC; k++) begin
                        if (sel.ctx == 8'(c) && sel.idx == 10'((k + 1) / 32)) begin
                            rd_mux[(k + 1) % 32] = enab_q[c][k];
                        end
                    end
                end
            end
            RG_THR: begin
                for (int c = 0; c < N_CTX; c++) begin
                    if (sel.ctx == 8'(c)) rd_mux = 32'(thr_q[c]);
                end
            end
            RG_CLAIM: rd_mux = 32'(sel_best);
            default:  rd_mux = '0;
        endcase
    end

    // Register state.
    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q  <= '0;
            enab_q  <= '0;
            thr_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (reg_rd) begin
                rdata_q <= rd_mux;
            end
            if (reg_wr) begin
                for (int k = 0; k < N_SRC; k++) begin
                    if (sel.kind == RG_PRIO && sel.idx == 10'(k + 1)) begin
                        prio_q[k] <= reg_wdata[PRIO_W-1:0];
                    end
                end
                for (int c = 0; c < N_CTX; c++) begin
                    if (sel.ctx == 8'(c)) begin
                        if (sel.kind == RG_THR) begin
                            thr_q[c] <= reg_wdata[PRIO_W-1:0];
                        end
                        for (int k = 0; k < N_SRC; k++) begin
                            if (sel.kind == RG_ENAB && sel.idx == 10'((k + 1) / 32)) begin
                                enab_q[c][k] <= reg_wdata[(k + 1) % 32];
                            end
                        end
                    end
                end
            end
        end
    end

    assign reg_rdata = rdata_q;

endmodule

// File: rtl/plic_core_checker.sv
module plic_core_checker #(
    parameter int unsigned N_SRC = 31,
    parameter int unsigned N_CTX = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   reg_rd,
    input logic [21:0]            reg_addr,
    input logic [31:0]            reg_rdata,
    input logic [N_CTX-1:0]       ctx_irq,
    input logic [N_CTX-1:0][2:0]  thr,
    input logic [N_SRC-1:0]       gw_pend,
    input logic [N_SRC-1:0]       gw_busy,
    input logic [N_SRC-1:0]       claim_vec
);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> ctx_irq == '0); // R1

    AST_PEND_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
        (gw_pend & gw_busy) == '0); // R7

    AST_CLAIM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(claim_vec)); // R6

    AST_CLAIM_FROM_PENDING: assert property (@(posedge clk) disable iff (rst)
        (claim_vec & ~gw_pend) == '0); // R6

    AST_CLAIM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        claim_vec != '0 |=> ((claim_vec | $past(claim_vec)) & $past(claim_vec) & gw_pend) == '0
                            && ($past(claim_vec) & ~gw_busy) == '0); // R7

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx_chk
        AST_THR_MAX_SILENT: assert property (@(posedge clk) disable iff (rst)
            thr[c] == 3'd7 |-> !ctx_irq[c]); // R5

        AST_EMPTY_CLAIM_ZERO: assert property (@(posedge clk) disable iff (rst)
            reg_rd && reg_addr == 22'(32'h0020_0004 + c * 32'h1000) && !ctx_irq[c]
            |=> reg_rdata == '0); // R6
    end

endmodule

bind plic_core plic_core_checker #(.N_SRC(N_SRC), .N_CTX(N_CTX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .ctx_irq   (ctx_irq),
    .thr       (thr_q),
    .gw_pend   (gw_pend),
    .gw_busy   (gw_busy),
    .claim_vec (claim_vec)
);

// File: tb/plic_core_bench.sv
module plic_core_bench;

    localparam int unsigned N_SRC = 31;
    localparam int unsigned N_CTX = 2;
    // IDs 5 and 6 are edge-captured (mask bit k is ID k+1).
    localparam logic [N_SRC-1:0] EDGE_MASK = 31'h30;

    localparam logic [1:0] OP_W = 2'd1;
    localparam logic [1:0] OP_R = 2'd2;
    localparam int NV = 29;

    // {op[91:90], addr[89:68], data[67:36], expect[35:4], req[3:0]}
    localparam logic [91:0] VECS [NV] = '{
        {OP_R, 22'h000000C, 32'h0, 32'h0, 4'd1},          // R1 prio reset
        {OP_R, 22'h0002000, 32'h0, 32'h0, 4'd1},          // R1 enable reset
        {OP_R, 22'h0201000, 32'h0, 32'h0, 4'd1},          // R1 threshold reset
        {OP_W, 22'h000000C, 32'h7, 32'h0, 4'd0},
        {OP_R, 22'h000000C, 32'h0, 32'h7, 4'd2},          // R2
        {OP_W, 22'h000000C, 32'hFFFF_FFFA, 32'h0, 4'd0},
        {OP_R, 22'h000000C, 32'h0, 32'h2, 4'd2},          // R2 3-bit field
        {OP_W, 22'h0000000, 32'h5, 32'h0, 4'd0},
        {OP_R, 22'h0000000, 32'h0, 32'h0, 4'd2},          // R2 ID 0
        {OP_W, 22'h000007C, 32'h4, 32'h0, 4'd0},
        {OP_R, 22'h000007C, 32'h0, 32'h4, 4'd2},          // R2 last ID
        {OP_W, 22'h0002000, 32'hFFFF_FFFF, 32'h0, 4'd0},
        {OP_R, 22'h0002000, 32'h0, 32'hFFFF_FFFE, 4'd3},  // R3 bit 0 fixed
        {OP_W, 22'h0002080, 32'h10, 32'h0, 4'd0},
        {OP_R, 22'h0002080, 32'h0, 32'h10, 4'd3},         // R3 ctx1
        {OP_R, 22'h0002000, 32'h0, 32'hFFFF_FFFE, 4'd3},  // R3 independence
        {OP_W, 22'h0200000, 32'h5, 32'h0, 4'd0},
        {OP_R, 22'h0200000, 32'h0, 32'h5, 4'd4},          // R4
        {OP_W, 22'h0201000, 32'hF, 32'h0, 4'd0},
        {OP_R, 22'h0201000, 32'h0, 32'h7, 4'd4},          // R4 3-bit field
        {OP_R, 22'h0200000, 32'h0, 32'h5, 4'd4},          // R4 ctx0 kept
        {OP_R, 22'h0201004, 32'h0, 32'h0, 4'd6},          // R6 empty claim
        {OP_W, 22'h0001000, 32'h1, 32'h0, 4'd0},
        {OP_R, 22'h0001000, 32'h0, 32'h0, 4'd11},         // R11
        {OP_R, 22'h0000080, 32'h0, 32'h0, 4'd11},         // R11 ID past range
        {OP_R, 22'h0002004, 32'h0, 32'h0, 4'd11},         // R11 enable word 1
        {OP_W, 22'h0200008, 32'h3, 32'h0, 4'd0},
        {OP_R, 22'h0200008, 32'h0, 32'h0, 4'd11},         // R11 ctrl gap
        {OP_R, 22'h0202000, 32'h0, 32'h0, 4'd11}          // R11 ctx 2
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_SRC-1:0]  src_req = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [21:0]       reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [N_CTX-1:0]  ctx_irq;

    int applied = 0;
    int fails   = 0;

    always #5 clk = ~clk;

    plic_core #(.N_SRC(N_SRC), .N_CTX(N_CTX), .EDGE_MASK(EDGE_MASK)) u_plic_core (
        .clk       (clk),
        .rst       (rst),
        .src_req   (src_req),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctx_irq   (ctx_irq)
    );

    function automatic logic [21:0] a_prio(input int id);  return 22'(4 * id); endfunction
    function automatic logic [21:0] a_en(input int c);     return 22'(32'h2000 + 32'h80 * c); endfunction
    function automatic logic [21:0] a_thr(input int c);    return 22'(32'h20_0000 + 32'h1000 * c); endfunction
    function automatic logic [21:0] a_clm(input int c);    return 22'(32'h20_0004 + 32'h1000 * c); endfunction

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [21:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [21:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, run incomplete");
        report();
    end

    initial begin
        logic [31:0] got;
        do_reset();

        // Register map table.
        for (int i = 0; i < NV; i++) begin
            if (VECS[i][91:90] == OP_W) begin
                wr(VECS[i][89:68], VECS[i][67:36]);
            end else begin
                rd(VECS[i][89:68], got);
                chk($sformatf("R%0d vec%0d", VECS[i][3:0], i), got, VECS[i][35:4]);
            end
        end

        // Directed: reset state (R1).
        do_reset();
        chk("R1 irq after reset", 32'(ctx_irq), 32'h0);
        rd(a_clm(0), got);
        chk("R1 claim after reset", got, 32'h0);

        // Eligibility (R5).
        wr(a_prio(3), 32'd2);
        @(negedge clk); src_req[2] = 1'b1;
        idle(1);
        chk("R5 not enabled", 32'(ctx_irq), 32'h0);
        wr(a_en(0), 32'h8);
        chk("R5 enabled ctx0", 32'(ctx_irq), 32'h1);
        wr(a_thr(0), 32'd2);
        chk("R5 prio equals threshold", 32'(ctx_irq[0]), 32'h0);
        wr(a_thr(0), 32'd1);
        chk("R5 prio above threshold", 32'(ctx_irq[0]), 32'h1);
        wr(a_thr(0), 32'd7);
        chk("R5 threshold 7", 32'(ctx_irq[0]), 32'h0);
        wr(a_thr(0), 32'd0);
        wr(a_prio(3), 32'd0);
        chk("R5 priority 0", 32'(ctx_irq[0]), 32'h0);
        wr(a_prio(3), 32'd2);

        // Claim, blocking and completion (R6, R7, R10).
        rd(a_clm(0), got);
        chk("R6 claim id", got, 32'd3);
        chk("R7 blocked after claim", 32'(ctx_irq[0]), 32'h0);
        idle(3);
        chk("R7 still blocked", 32'(ctx_irq[0]), 32'h0);
        rd(a_clm(0), got);
        chk("R6 empty claim", got, 32'd0);
        wr(a_clm(0), 32'd0);
        idle(2);
        chk("R10 complete id 0", 32'(ctx_irq[0]), 32'h0);
        wr(a_clm(1), 32'd3);
        idle(2);
        chk("R10 complete wrong ctx", 32'(ctx_irq[0]), 32'h0);
        wr(a_clm(0), 32'd3);
        idle(1);
        chk("R7 level repends", 32'(ctx_irq[0]), 32'h1);
        @(negedge clk); src_req[2] = 1'b0;
        rd(a_clm(0), got);
        chk("R7 reclaim", got, 32'd3);
        wr(a_clm(0), 32'd3);
        idle(2);
        chk("R7 level low no repend", 32'(ctx_irq[0]), 32'h0);

        // Priority order and tie (R6).
        wr(a_prio(2), 32'd5);
        wr(a_prio(4), 32'd5);
        wr(a_en(0), 32'h1C);
        @(negedge clk); src_req[1] = 1'b1; src_req[2] = 1'b1; src_req[3] = 1'b1;
        @(negedge clk); src_req[1] = 1'b0; src_req[2] = 1'b0; src_req[3] = 1'b0;
        rd(a_clm(0), got);
        chk("R6 tie lowest id", got, 32'd2);
        rd(a_clm(0), got);
        chk("R6 tie second", got, 32'd4);
        rd(a_clm(0), got);
        chk("R6 lower priority", got, 32'd3);
        rd(a_clm(0), got);
        chk("R6 drained", got, 32'd0);
        wr(a_clm(0), 32'd2);
        wr(a_clm(0), 32'd4);
        wr(a_clm(0), 32'd3);

        // Edge capture (R8).
        wr(a_prio(5), 32'd3);
        wr(a_en(0), 32'h3C);
        @(negedge clk); src_req[4] = 1'b1;
        idle(1);
        chk("R8 edge pends", 32'(ctx_irq[0]), 32'h1);
        rd(a_clm(0), got);
        chk("R8 claim edge id", got, 32'd5);
        wr(a_clm(0), 32'd5);
        idle(3);
        chk("R8 held high no repend", 32'(ctx_irq[0]), 32'h0);
        @(negedge clk); src_req[4] = 1'b0;

        // Edge remembered while claimed (R9).
        @(negedge clk); src_req[4] = 1'b1;
        @(negedge clk); src_req[4] = 1'b0;
        rd(a_clm(0), got);
        chk("R9 claim", got, 32'd5);
        @(negedge clk); src_req[4] = 1'b1;
        @(negedge clk); src_req[4] = 1'b0;
        @(negedge clk); src_req[4] = 1'b1;
        @(negedge clk); src_req[4] = 1'b0;
        idle(1);
        chk("R9 held during claim", 32'(ctx_irq[0]), 32'h0);
        wr(a_clm(0), 32'd5);
        chk("R9 pends at completion", 32'(ctx_irq[0]), 32'h1);
        rd(a_clm(0), got);
        chk("R9 reclaim", got, 32'd5);
        wr(a_clm(0), 32'd5);
        idle(2);
        chk("R9 only one remembered", 32'(ctx_irq[0]), 32'h0);

        report();
    end

endmodule